// File: doc/BRIEF.md
# Four-state snooping coherence controller

This block keeps one small direct-mapped write-back cache coherent with its peers on an atomic shared bus. Each line carries a tag, one data word and one of four coherence states: invalid, shared, exclusive-clean or modified. Processor reads and writes arrive on a valid/ready port. A hit that needs no bus work completes in the same cycle. Otherwise the controller requests the bus and, once granted, performs a read, a read-for-ownership, an ownership upgrade or a writeback. It then finishes the processor request in the cycle of the grant.

The controller also watches the transactions that other caches put on the bus. A snooped read that finds a valid copy drives a wired-OR shared signal and demotes the line to shared. A modified line supplies its word, which memory also takes. Ownership requests from other caches invalidate the local copy. When this cache fills a line for a read, it samples the shared signal: if nobody else holds the line it fills exclusive-clean, and a later write then needs no bus traffic. Clean lines are replaced silently, while a modified victim is written back before the new fill.

The bus is atomic: a granted transaction, the memory access and all state changes happen in one clock. The arbiter never grants this cache in a cycle that carries another cache's transaction.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, so the first access to any index raises `bus_req` for a fill.
- R2: A read that hits a line in shared, exclusive-clean or modified state raises `cpu_ready` in the same cycle with the stored word on `cpu_rdata` and no bus request.
- R3: A read miss with a clean or invalid victim requests command 0 (read) at the processor address. In the grant cycle it completes with `bus_rdata` on `cpu_rdata`. The line fills exclusive-clean if `bus_shared_i` is low and shared if it is high.
- R4: A write miss with a clean or invalid victim requests command 1 (read-for-ownership) at the processor address. In the grant cycle it completes, and the line becomes modified holding the write data.
- R5: A write hit on a shared line requests command 2 (upgrade) with no data and becomes modified on grant. A write hit on an exclusive-clean or modified line completes in the same cycle without a bus request and leaves the line modified.
- R6: A miss whose victim is modified first requests command 3 (writeback). The bus address is the victim's tag above the index and `bus_wdata` is the victim word. The grant does not complete the processor request, and the line becomes invalid, so the fill follows.
- R7: A snooped read (command 0) that hits a valid line raises `snp_shared` in the same cycle, and the line becomes shared.
- R8: A snooped read or read-for-ownership that hits a modified line raises `snp_supply` with the line word on `snp_data`. A snooped read-for-ownership or upgrade that hits invalidates the line. A snooped writeback changes nothing.
- R9: A processor request to the index being snooped in the same cycle neither completes nor requests the bus.
- R10: `cpu_ready` is raised only while `cpu_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address (tag above index) |
| cpu_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DW | Read data, valid with ready on a read |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Grant; the transaction happens in this cycle |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 writeback |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Writeback word |
| bus_rdata | input | DW | Fill word from memory or a supplying cache |
| bus_shared_i | input | 1 | Wired-OR shared signal from the other caches |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | AW | Snooped address |
| snp_shared | output | 1 | This cache holds a valid copy of the snooped read |
| snp_supply | output | 1 | This cache supplies the snooped line |
| snp_data | output | DW | Supplied word |

## Verification
The hardest situation to reach is a pending upgrade whose shared line is taken away by another cache's ownership request before the grant arrives. The request must then turn into a read-for-ownership instead of an upgrade. A second hard case is a modified victim that must be written back before its replacement is fetched. The stimulus gets there by drawing addresses from four tags over eight lines, withholding the grant in many cycles, and placing snoops from the same address pool in the idle bus cycles. A behavioural model of the line states judges every cycle.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {BC_RD = 2'd0, BC_RDX = 2'd1, BC_UPG = 2'd2, BC_WB = 2'd3} bus_cmd_t;

  // state a line takes after observing another cache's transaction
  function automatic line_st_t snoop_next(line_st_t cur, bus_cmd_t cmd);
    case (cmd)
      BC_RD:          return (cur == ST_I) ? ST_I : ST_S;
      BC_RDX, BC_UPG: return ST_I;
      default:        return cur;
    endcase
  endfunction

  // state a line takes when filled by this cache
  function automatic line_st_t fill_state(logic is_write, logic others_share);
    if (is_write) return ST_M;
    return others_share ? ST_S : ST_E;
  endfunction

  function automatic logic must_supply(line_st_t cur, bus_cmd_t cmd);
    return (cur == ST_M) && (cmd == BC_RD || cmd == BC_RDX);
  endfunction
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int LINES = 8,
  parameter int TW    = 5,
  parameter int DW    = 16,
  localparam int IW   = $clog2(LINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   a_idx,
  output line_st_t        a_st,
  output logic [TW-1:0]   a_tag,
  output logic [DW-1:0]   a_dat,
  input  logic [IW-1:0]   b_idx,
  output line_st_t        b_st,
  output logic [TW-1:0]   b_tag,
  output logic [DW-1:0]   b_dat,
  input  logic            c_we,
  input  line_st_t        c_st,
  input  logic [TW-1:0]   c_tag,
  input  logic [DW-1:0]   c_dat,
  input  logic            s_we,
  input  line_st_t        s_st,
  output logic [2*LINES-1:0] st_flat
);
  line_st_t        st_q  [LINES];
  logic [TW-1:0]   tag_q [LINES];
  logic [DW-1:0]   dat_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                st_q[i] <= ST_I;
      else if (c_we && a_idx == IW'(i))          st_q[i] <= c_st;
      else if (s_we && b_idx == IW'(i))          st_q[i] <= s_st;
    end
    always_ff @(posedge clk) begin
      if (c_we && a_idx == IW'(i)) begin
        tag_q[i] <= c_tag;
        dat_q[i] <= c_dat;
      end
    end
    assign st_flat[2*i +: 2] = st_q[i];
  end

  assign a_st  = st_q[a_idx];
  assign a_tag = tag_q[a_idx];
  assign a_dat = dat_q[a_idx];
  assign b_st  = st_q[b_idx];
  assign b_tag = tag_q[b_idx];
  assign b_dat = dat_q[b_idx];
endmodule

// File: rtl/mesi_cpu_side.sv
module mesi_cpu_side
  import mesi_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int IW = 3,
  localparam int TW = AW - IW
) (
  input  logic          cpu_valid,
  input  logic          cpu_write,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          blocked,
  input  line_st_t      l_st,
  input  logic [TW-1:0] l_tag,
  input  logic [DW-1:0] l_dat,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_shared_i,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  output bus_cmd_t      bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          c_we,
  output line_st_t      c_st,
  output logic [TW-1:0] c_tag,
  output logic [DW-1:0] c_dat,
  output logic          ev_fill,
  output logic          ev_upg,
  output logic          ev_wb
);
  logic [TW-1:0] req_tag;
  logic          hit;
  assign req_tag   = cpu_addr[AW-1:IW];
  assign hit       = (l_st != ST_I) && (l_tag == req_tag);
  assign cpu_rdata = hit ? l_dat : bus_rdata;

  always_comb begin
    cpu_ready = 1'b0;
    bus_req   = 1'b0;
    bus_cmd   = BC_RD;
    bus_addr  = cpu_addr;
    bus_wdata = '0;
    c_we      = 1'b0;
    c_st      = l_st;
    c_tag     = l_tag;
    c_dat     = l_dat;
    ev_fill   = 1'b0;
    ev_upg    = 1'b0;
    ev_wb     = 1'b0;
    if (cpu_valid && !blocked) begin
      if (hit && (!cpu_write || l_st != ST_S)) begin
        cpu_ready = 1'b1;
        if (cpu_write) begin
          c_we  = 1'b1;
          c_st  = ST_M;
          c_dat = cpu_wdata;
        end
      end else begin
        bus_req = 1'b1;
        if (hit) begin
          bus_cmd = BC_UPG;
        end else if (l_st == ST_M) begin
          bus_cmd   = BC_WB;
          bus_addr  = {l_tag, cpu_addr[IW-1:0]};
          bus_wdata = l_dat;
        end else begin
          bus_cmd = cpu_write ? BC_RDX : BC_RD;
        end
        if (bus_gnt) begin
          c_we = 1'b1;
          case (bus_cmd)
            BC_WB: begin
              c_st  = ST_I;
              ev_wb = 1'b1;
            end
            BC_UPG: begin
              cpu_ready = 1'b1;
              c_st      = ST_M;
              c_dat     = cpu_wdata;
              ev_upg    = 1'b1;
            end
            default: begin
              cpu_ready = 1'b1;
              c_st      = fill_state(cpu_write, bus_shared_i);
              c_tag     = req_tag;
              c_dat     = cpu_write ? cpu_wdata : bus_rdata;
              ev_fill   = 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mesi_snoop_side.sv
module mesi_snoop_side
  import mesi_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int IW = 3,
  localparam int TW = AW - IW
) (
  input  logic          snp_valid,
  input  bus_cmd_t      snp_cmd,
  input  logic [AW-1:0] snp_addr,
  input  line_st_t      l_st,
  input  logic [TW-1:0] l_tag,
  input  logic [DW-1:0] l_dat,
  output logic          snp_hit,
  output logic          snp_shared,
  output logic          snp_supply,
  output logic [DW-1:0] snp_data,
  output logic          s_we,
  output line_st_t      s_st
);
  assign snp_hit    = snp_valid && (l_st != ST_I) && (l_tag == snp_addr[AW-1:IW]);
  assign snp_shared = snp_hit && (snp_cmd == BC_RD);
  assign snp_supply = snp_hit && must_supply(l_st, snp_cmd);
  assign snp_data   = snp_supply ? l_dat : '0;
  assign s_we       = snp_hit;
  assign s_st       = snoop_next(l_st, snp_cmd);
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int LINES = 8,
  localparam int IW   = $clog2(LINES),
  localparam int TW   = AW - IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  input  logic          cpu_write,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_shared_i,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_shared,
  output logic          snp_supply,
  output logic [DW-1:0] snp_data
);
  line_st_t      a_st, b_st, c_st, s_st;
  logic [TW-1:0] a_tag, b_tag, c_tag;
  logic [DW-1:0] a_dat, b_dat, c_dat;
  logic          c_we, s_we, snp_hit, blocked;
  bus_cmd_t      cmd_int;
  logic          ev_fill, ev_upg, ev_wb;
  logic [2*LINES-1:0] st_flat;

  // one bus, one owner per cycle: a snoop on the same index holds off the processor
  assign blocked = snp_valid && (snp_addr[IW-1:0] == cpu_addr[IW-1:0]);
  assign bus_cmd = cmd_int;

  mesi_line_store #(.LINES(LINES), .TW(TW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(cpu_addr[IW-1:0]), .a_st(a_st), .a_tag(a_tag), .a_dat(a_dat),
    .b_idx(snp_addr[IW-1:0]), .b_st(b_st), .b_tag(b_tag), .b_dat(b_dat),
    .c_we(c_we), .c_st(c_st), .c_tag(c_tag), .c_dat(c_dat),
    .s_we(s_we), .s_st(s_st), .st_flat(st_flat)
  );

  mesi_cpu_side #(.AW(AW), .DW(DW), .IW(IW)) u_cpu (
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .blocked(blocked),
    .l_st(a_st), .l_tag(a_tag), .l_dat(a_dat),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .bus_shared_i(bus_shared_i),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(cmd_int), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .c_we(c_we), .c_st(c_st), .c_tag(c_tag), .c_dat(c_dat),
    .ev_fill(ev_fill), .ev_upg(ev_upg), .ev_wb(ev_wb)
  );

  mesi_snoop_side #(.AW(AW), .DW(DW), .IW(IW)) u_snp (
    .snp_valid(snp_valid), .snp_cmd(bus_cmd_t'(snp_cmd)), .snp_addr(snp_addr),
    .l_st(b_st), .l_tag(b_tag), .l_dat(b_dat),
    .snp_hit(snp_hit), .snp_shared(snp_shared), .snp_supply(snp_supply),
    .snp_data(snp_data), .s_we(s_we), .s_st(s_st)
  );
endmodule

// File: rtl/mesi_snoop_chk.sv
module mesi_snoop_chk #(
  parameter int AW    = 8,
  parameter int LINES = 8,
  localparam int IW   = $clog2(LINES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_valid,
  input logic               cpu_write,
  input logic [AW-1:0]      cpu_addr,
  input logic               cpu_ready,
  input logic               bus_req,
  input logic               bus_gnt,
  input logic [1:0]         bus_cmd,
  input logic               bus_shared_i,
  input logic               snp_valid,
  input logic [1:0]         snp_cmd,
  input logic [AW-1:0]      snp_addr,
  input logic               snp_shared,
  input logic               snp_supply,
  input logic               ev_fill,
  input logic               ev_upg,
  input logic               ev_wb,
  input logic [2*LINES-1:0] st_flat
);
  logic [IW-1:0] cidx;
  assign cidx = cpu_addr[IW-1:0];

  assert_ready_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid);

  assert_snoop_blocks_cpu_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_addr[IW-1:0] == cidx) |-> (!cpu_ready && !bus_req));

  assert_shared_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared |-> (snp_valid && snp_cmd == 2'd0));

  assert_supply_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (snp_valid && snp_cmd != 2'd2 && snp_cmd != 2'd3));

  assert_wb_not_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && bus_cmd == 2'd3) |-> !cpu_ready);

  assert_wb_invalidates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb |=> st_flat[2*$past(cidx) +: 2] == 2'd0);

  assert_upg_to_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_upg |=> st_flat[2*$past(cidx) +: 2] == 2'd3);

  assert_lone_fill_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fill && !cpu_write && !bus_shared_i) |=> st_flat[2*$past(cidx) +: 2] == 2'd2);

  assert_rfo_fill_mod_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fill && cpu_write) |=> st_flat[2*$past(cidx) +: 2] == 2'd3);
endmodule

bind mesi_snoop_ctrl mesi_snoop_chk #(.AW(AW), .LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
  .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_cmd(bus_cmd), .bus_shared_i(bus_shared_i), .snp_valid(snp_valid),
  .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_shared(snp_shared),
  .snp_supply(snp_supply), .ev_fill(ev_fill), .ev_upg(ev_upg), .ev_wb(ev_wb),
  .st_flat(st_flat)
);

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb;
  localparam int AW = 8, DW = 16, LINES = 8;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cpu_valid = 0, cpu_write = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req, bus_gnt, gnt_en = 0;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          bus_shared_i = 0, snp_valid = 0;
  logic [1:0]    snp_cmd = 0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_shared, snp_supply;
  logic [DW-1:0] snp_data;

  logic [DW-1:0] mem [256];
  int            m_st  [LINES];   // 0 I, 1 S, 2 E, 3 M
  int            m_tag [LINES];
  logic [DW-1:0] m_dat [LINES];
  int n_cmp = 0, n_bad = 0;
  bit done = 0, e_rdy = 0;

  assign bus_gnt   = bus_req & gnt_en;
  assign bus_rdata = mem[bus_addr];

  always #5 clk = ~clk;

  mesi_snoop_ctrl #(.AW(AW), .DW(DW), .LINES(LINES)) u_dut (.*);

  task automatic chk(string rq, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // behavioural reference: judge this cycle's outputs, then advance the model
  task automatic step_model();
    int ci = cpu_addr % LINES, ct = cpu_addr / LINES;
    int si = snp_addr % LINES, stg = snp_addr / LINES;
    int e_req = 0, e_cmd = 0, e_addr = 0, e_wd = 0, e_rd = 0;
    bit shit, e_sh, e_sup, chit;
    string rq = "R10";
    e_rdy = 0;
    shit  = snp_valid && m_st[si] != 0 && m_tag[si] == stg;
    e_sh  = shit && snp_cmd == 0;
    e_sup = shit && m_st[si] == 3 && (snp_cmd == 0 || snp_cmd == 1);
    chit  = m_st[ci] != 0 && m_tag[ci] == ct;
    if (cpu_valid && snp_valid && si == ci) rq = "R9";
    else if (cpu_valid) begin
      if (chit && (!cpu_write || m_st[ci] != 1)) begin
        e_rdy = 1; e_rd = m_dat[ci]; rq = cpu_write ? "R5" : "R2";
      end else begin
        e_req = 1; e_addr = cpu_addr;
        if (chit) begin e_cmd = 2; rq = "R5"; end
        else if (m_st[ci] == 3) begin
          e_cmd = 3; rq = "R6"; e_addr = m_tag[ci] * LINES + ci; e_wd = m_dat[ci];
        end else begin e_cmd = cpu_write ? 1 : 0; rq = cpu_write ? "R4" : "R3"; end
        if (gnt_en && e_cmd != 3) begin e_rdy = 1; e_rd = mem[cpu_addr]; end
      end
    end
    chk(rq, "cpu_ready", cpu_ready, e_rdy);
    if (e_rdy && !cpu_write) chk(rq, "cpu_rdata", cpu_rdata, e_rd);
    chk(rq, "bus_req", bus_req, e_req);
    if (e_req) begin
      chk(rq, "bus_cmd", bus_cmd, e_cmd);
      chk(rq, "bus_addr", bus_addr, e_addr);
      if (e_cmd == 3) chk(rq, "bus_wdata", bus_wdata, e_wd);
    end
    chk("R7", "snp_shared", snp_shared, e_sh);
    chk("R8", "snp_supply", snp_supply, e_sup);
    if (e_sup) chk("R8", "snp_data", snp_data, m_dat[si]);
    // advance: snoop effect, then this cache's own change
    if (e_sup) mem[snp_addr] = m_dat[si];
    if (shit) m_st[si] = (snp_cmd == 0) ? 1 : (snp_cmd == 3 ? m_st[si] : 0);
    if (e_req && gnt_en) begin
      case (e_cmd)
        3: begin mem[e_addr] = m_dat[ci]; m_st[ci] = 0; end
        2: begin m_st[ci] = 3; m_dat[ci] = cpu_wdata; end
        default: begin
          m_tag[ci] = ct;
          m_st[ci]  = cpu_write ? 3 : (bus_shared_i ? 1 : 2);
          m_dat[ci] = cpu_write ? cpu_wdata : e_rd;
        end
      endcase
    end else if (e_rdy && cpu_write) begin
      m_st[ci] = 3; m_dat[ci] = cpu_wdata;
    end
  endtask

  function automatic logic [AW-1:0] pick_addr();
    return AW'(($urandom % 4) * LINES + ($urandom % LINES));
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = DW'(i * 97 + 13);
    for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cpu_ready after reset", cpu_ready, 0);
    chk("R1", "bus_req after reset", bus_req, 0);
    // directed: first touch of every index must go to the bus
    for (int i = 0; i < LINES; i++) begin
      @(posedge clk); #1;
      cpu_valid = 1; cpu_write = (i % 2); cpu_addr = AW'(i); cpu_wdata = DW'(16'hA000 + i);
      gnt_en = 0; bus_shared_i = (i % 3 == 0);
      @(negedge clk);
      chk("R1", "first access requests bus", bus_req, 1);
      step_model();
      @(posedge clk); #1 gnt_en = 1;
      @(negedge clk);
      step_model();
    end
    @(posedge clk); #1 cpu_valid = 0; gnt_en = 0;
    @(negedge clk); step_model();
    // mixed traffic with peers snooping in idle bus cycles
    for (int n = 0; n < 6000; n++) begin
      @(posedge clk); #1;
      if (!cpu_valid || e_rdy) begin
        cpu_valid = ($urandom % 8) != 0;
        cpu_write = $urandom % 2;
        cpu_addr  = pick_addr();
        cpu_wdata = DW'($urandom);
      end
      snp_valid    = ($urandom % 10) < 3;
      snp_cmd      = 2'($urandom % 4);
      snp_addr     = pick_addr();
      gnt_en       = !snp_valid && (($urandom % 10) < 6);
      bus_shared_i = $urandom % 2;
      @(negedge clk);
      step_model();
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired before end of stimulus");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule